// File: doc/BRIEF.md
# Double-Buffered GEMM Tile Sequencer

This controller walks a matrix multiply C += A·B (A is M×K, B is K×N, C is M×N, all row-major with 2-byte elements) through a grid of output tiles. Each tile is at most 32 elements along each axis. For every output tile it brings the C tile into scratchpad partition 1 and keeps it there for the whole reduction over k. For every k-slice it then fetches a B tile into partition 1, makes sure the matching A tile sits in partition 0, and starts an external tile multiply engine. The C tile is written back once, after the last slice.

Partition 0 is split into two slots. While the multiply engine works on the A tile in one slot, the next A tile is fetched into the other slot. When two steps in a row use the same A tile, the tile already resident is reused and no fetch is issued. The DMA engine and the multiply engine sit outside the block. Each one answers a request strobe with a one-cycle completion pulse, which must come at least one cycle after the request.

Top module: `gemm_tile_seq`

## Requirements
- R1: Tile counts are ceil(M/32), ceil(N/32) and ceil(K/32). Every descriptor carries row extent min(32, rows_total − 32·row_tile) and column extent min(32, cols_total − 32·col_tile).
- R2: Steps run with i (output tile row) outermost, j (output tile column) next and k innermost. On partition 1 each output tile (i,j) produces, in order: a C load (kind 0) with tile coordinates (i,j); one B load (kind 1) with coordinates (k,j) for each k; one C store (kind 2) with coordinates (i,j). Partition 0 requests carry A tiles with coordinates (i,k).
- R3: A descriptor address is base + (32·row_tile·stride + 32·col_tile)·2. The stride is K for A and N for both B and C. The base is the A, B or C base latched at start.
- R4: mm_start is raised only when no partition has a transfer outstanding. When it is raised, the correct A, B and C tiles are resident. Partition 1 never has more than one transfer outstanding.
- R5: The first A tile of a job (slot 0) and the first C load are requested in the same cycle.
- R6: Every A request after the first of a job is issued in the same cycle as mm_start, into the slot (0 or 1) other than mm_a_slot. mm_a_slot always names the slot that holds the A tile for the step being computed.
- R7: When the next step needs the same A tile as the current step, no A request is made, so a job issues ceil(M/32) A requests when K ≤ 32 and MT·NT·KT otherwise.
- R8: The C store for an output tile is requested only after the multiply engine has completed all KT slices of that tile, and one cycle after the last completion pulse.
- R9: done is high for exactly one cycle, two cycles after the final store acknowledge. busy is high from the cycle after an accepted start through the done cycle.
- R10: A start pulse while busy is ignored. The running job keeps its latched dimensions and bases.
- R11: If any dimension is zero the job raises done with no DMA or multiply request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| dim_m | input | DIM_W | Rows of A and C |
| dim_n | input | DIM_W | Columns of B and C |
| dim_k | input | DIM_W | Reduction length |
| base_a | input | ADDR_W | Byte base of A |
| base_b | input | ADDR_W | Byte base of B |
| base_c | input | ADDR_W | Byte base of C |
| p0_req | output | 1 | Partition 0 (A) load request strobe |
| p0_addr | output | ADDR_W | A tile byte address |
| p0_row_tile | output | DIM_W−TLOG+1 | A tile row index i |
| p0_col_tile | output | DIM_W−TLOG+1 | A tile column index k |
| p0_rows | output | TLOG+1 | A tile row extent |
| p0_cols | output | TLOG+1 | A tile column extent |
| p0_slot | output | 1 | Destination slot in partition 0 |
| p0_ack | input | 1 | Partition 0 transfer complete |
| p1_req | output | 1 | Partition 1 request strobe |
| p1_kind | output | 2 | 0 C load, 1 B load, 2 C store |
| p1_addr | output | ADDR_W | Tile byte address |
| p1_row_tile | output | DIM_W−TLOG+1 | Tile row index |
| p1_col_tile | output | DIM_W−TLOG+1 | Tile column index |
| p1_rows | output | TLOG+1 | Row extent |
| p1_cols | output | TLOG+1 | Column extent |
| p1_ack | input | 1 | Partition 1 transfer complete |
| mm_start | output | 1 | Tile multiply start strobe |
| mm_a_slot | output | 1 | Partition 0 slot holding the A operand |
| mm_done | input | 1 | Tile multiply complete, C updated |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle job completion |

## Verification
The bench uses the default parameters: DIM_W=16, TLOG=5 (32-element tiles) and ADDR_W=32. Dimensions run from 0 to 140, which gives up to five tiles per axis. That range covers partial edge tiles, exact multiples of 32, single-tile problems, the K ≤ 32 reuse path and the zero-dimension early exit. Responder latencies are drawn at random, so prefetch completion can land before, during or after the multiply. This exercises the slot bookkeeping and the wait-for-both-partitions rule.

// File: rtl/gts_pkg.sv
package gts_pkg;

  // Partition 1 transfer kinds (encoding visible on p1_kind)
  typedef enum logic [1:0] {
    KIND_C_LOAD  = 2'd0,
    KIND_B_LOAD  = 2'd1,
    KIND_C_STORE = 2'd2
  } p1_kind_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_LAUNCH,
    S_LDC,
    S_WLDC,
    S_LDB,
    S_WLDB,
    S_MM,
    S_WMM,
    S_ST,
    S_WST,
    S_FIN
  } seq_state_e;

endpackage

// File: rtl/gts_loop.sv
// Tile loop counters (i outer, j middle, k inner) with one-step lookahead.
module gts_loop #(
  parameter int DIM_W = 16,
  parameter int TLOG  = 5,
  localparam int TIDX_W = DIM_W - TLOG + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DIM_W-1:0]  dim_m,
  input  logic [DIM_W-1:0]  dim_n,
  input  logic [DIM_W-1:0]  dim_k,
  input  logic              step,
  output logic [TIDX_W-1:0] cur_i,
  output logic [TIDX_W-1:0] cur_j,
  output logic [TIDX_W-1:0] cur_k,
  output logic [TIDX_W-1:0] nx_i,
  output logic [TIDX_W-1:0] nx_k,
  output logic              last_k,
  output logic              has_next,
  output logic              any_zero
);

  localparam int TILE = 1 << TLOG;

  function automatic logic [TIDX_W-1:0] tiles_of(input logic [DIM_W-1:0] d);
    logic [DIM_W:0] sum;
    sum = {1'b0, d} + (DIM_W+1)'(TILE - 1);
    return TIDX_W'(sum >> TLOG);
  endfunction

  logic [TIDX_W-1:0] mt_q, nt_q, kt_q;
  logic [TIDX_W-1:0] i_q, j_q, k_q;
  logic [TIDX_W-1:0] i_d, j_d, k_d;
  logic              last_j, last_i;

  always_comb begin
    last_k   = (k_q == kt_q - TIDX_W'(1));
    last_j   = (j_q == nt_q - TIDX_W'(1));
    last_i   = (i_q == mt_q - TIDX_W'(1));
    has_next = !(last_k && last_j && last_i);
    any_zero = (mt_q == '0) || (nt_q == '0) || (kt_q == '0);
    nx_k     = last_k ? '0 : k_q + TIDX_W'(1);
    nx_i     = (last_k && last_j) ? i_q + TIDX_W'(1) : i_q;
    k_d      = nx_k;
    i_d      = nx_i;
    if (!last_k)     j_d = j_q;
    else if (last_j) j_d = '0;
    else             j_d = j_q + TIDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mt_q <= '0;
      nt_q <= '0;
      kt_q <= '0;
      i_q  <= '0;
      j_q  <= '0;
      k_q  <= '0;
    end else if (load) begin
      mt_q <= tiles_of(dim_m);
      nt_q <= tiles_of(dim_n);
      kt_q <= tiles_of(dim_k);
      i_q  <= '0;
      j_q  <= '0;
      k_q  <= '0;
    end else if (step) begin
      i_q <= i_d;
      j_q <= j_d;
      k_q <= k_d;
    end
  end

  assign cur_i = i_q;
  assign cur_j = j_q;
  assign cur_k = k_q;

  // Loop indices stay inside the tile grid (R1)
  assert_idx_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mt_q != '0 && nt_q != '0 && kt_q != '0) |-> (i_q < mt_q && j_q < nt_q && k_q < kt_q));

endmodule

// File: rtl/gts_desc.sv
// Tile descriptor: byte address and clipped extents of one tile.
module gts_desc #(
  parameter int DIM_W  = 16,
  parameter int TLOG   = 5,
  parameter int ADDR_W = 32,
  localparam int TIDX_W = DIM_W - TLOG + 1,
  localparam int OFF_W  = 2 * DIM_W + 3
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [TIDX_W-1:0] row_tile,
  input  logic [TIDX_W-1:0] col_tile,
  input  logic [DIM_W-1:0]  row_total,
  input  logic [DIM_W-1:0]  col_total,
  input  logic [DIM_W-1:0]  stride,
  output logic [ADDR_W-1:0] addr,
  output logic [TLOG:0]     rows,
  output logic [TLOG:0]     cols
);

  localparam logic [DIM_W:0] TILE_EXT = (DIM_W+1)'(1 << TLOG);

  logic [DIM_W:0]   row0, col0, row_rem, col_rem;
  logic [OFF_W-1:0] elem_off;

  always_comb begin
    row0     = {row_tile, {TLOG{1'b0}}};
    col0     = {col_tile, {TLOG{1'b0}}};
    row_rem  = {1'b0, row_total} - row0;
    col_rem  = {1'b0, col_total} - col0;
    rows     = (row_rem >= TILE_EXT) ? TILE_EXT[TLOG:0] : row_rem[TLOG:0];
    cols     = (col_rem >= TILE_EXT) ? TILE_EXT[TLOG:0] : col_rem[TLOG:0];
    elem_off = OFF_W'(row0) * OFF_W'(stride) + OFF_W'(col0);
    addr     = base + ADDR_W'({elem_off, 1'b0});
  end

endmodule

// File: rtl/gemm_tile_seq.sv
module gemm_tile_seq
  import gts_pkg::*;
#(
  parameter int DIM_W  = 16,
  parameter int TLOG   = 5,
  parameter int ADDR_W = 32,
  localparam int TIDX_W = DIM_W - TLOG + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIM_W-1:0]  dim_m,
  input  logic [DIM_W-1:0]  dim_n,
  input  logic [DIM_W-1:0]  dim_k,
  input  logic [ADDR_W-1:0] base_a,
  input  logic [ADDR_W-1:0] base_b,
  input  logic [ADDR_W-1:0] base_c,
  output logic              p0_req,
  output logic [ADDR_W-1:0] p0_addr,
  output logic [TIDX_W-1:0] p0_row_tile,
  output logic [TIDX_W-1:0] p0_col_tile,
  output logic [TLOG:0]     p0_rows,
  output logic [TLOG:0]     p0_cols,
  output logic              p0_slot,
  input  logic              p0_ack,
  output logic              p1_req,
  output logic [1:0]        p1_kind,
  output logic [ADDR_W-1:0] p1_addr,
  output logic [TIDX_W-1:0] p1_row_tile,
  output logic [TIDX_W-1:0] p1_col_tile,
  output logic [TLOG:0]     p1_rows,
  output logic [TLOG:0]     p1_cols,
  input  logic              p1_ack,
  output logic              mm_start,
  output logic              mm_a_slot,
  input  logic              mm_done,
  output logic              busy,
  output logic              done
);

  seq_state_e st_q, st_d;

  logic [DIM_W-1:0]  m_q, n_q, k_q;
  logic [ADDR_W-1:0] ba_q, bb_q, bc_q;
  logic              first_q, a_slot_q, swap_q;
  logic              p0_busy_q, p1_busy_q;
  logic              p0_busy_d, p1_busy_d;
  logic              accept, step, pf_need, in_mm;

  logic [TIDX_W-1:0] cur_i, cur_j, cur_k, nx_i, nx_k;
  logic              last_k, has_next, any_zero;

  logic [ADDR_W-1:0] b_addr, c_addr;
  logic [TLOG:0]     b_rows, b_cols, c_rows, c_cols;

  assign accept = (st_q == S_IDLE) && start;
  assign in_mm  = (st_q == S_MM);

  gts_loop #(.DIM_W(DIM_W), .TLOG(TLOG)) u_loop (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .dim_m    (dim_m),
    .dim_n    (dim_n),
    .dim_k    (dim_k),
    .step     (step),
    .cur_i    (cur_i),
    .cur_j    (cur_j),
    .cur_k    (cur_k),
    .nx_i     (nx_i),
    .nx_k     (nx_k),
    .last_k   (last_k),
    .has_next (has_next),
    .any_zero (any_zero)
  );

  // A operand: current step for the first fetch, next step while computing
  assign p0_row_tile = in_mm ? nx_i : cur_i;
  assign p0_col_tile = in_mm ? nx_k : cur_k;
  assign p0_slot     = in_mm ? ~a_slot_q : a_slot_q;
  assign pf_need     = has_next && ((nx_i != cur_i) || (nx_k != cur_k));

  gts_desc #(.DIM_W(DIM_W), .TLOG(TLOG), .ADDR_W(ADDR_W)) u_desc_a (
    .base      (ba_q),
    .row_tile  (p0_row_tile),
    .col_tile  (p0_col_tile),
    .row_total (m_q),
    .col_total (k_q),
    .stride    (k_q),
    .addr      (p0_addr),
    .rows      (p0_rows),
    .cols      (p0_cols)
  );

  gts_desc #(.DIM_W(DIM_W), .TLOG(TLOG), .ADDR_W(ADDR_W)) u_desc_b (
    .base      (bb_q),
    .row_tile  (cur_k),
    .col_tile  (cur_j),
    .row_total (k_q),
    .col_total (n_q),
    .stride    (n_q),
    .addr      (b_addr),
    .rows      (b_rows),
    .cols      (b_cols)
  );

  gts_desc #(.DIM_W(DIM_W), .TLOG(TLOG), .ADDR_W(ADDR_W)) u_desc_c (
    .base      (bc_q),
    .row_tile  (cur_i),
    .col_tile  (cur_j),
    .row_total (m_q),
    .col_total (n_q),
    .stride    (n_q),
    .addr      (c_addr),
    .rows      (c_rows),
    .cols      (c_cols)
  );

  // Next-state logic
  always_comb begin
    st_d = st_q;
    step = 1'b0;
    unique case (st_q)
      S_IDLE:   if (start) st_d = S_LAUNCH;
      S_LAUNCH: st_d = any_zero ? S_FIN : S_LDC;
      S_LDC:    st_d = S_WLDC;
      S_WLDC:   if (!p1_busy_q) st_d = S_LDB;
      S_LDB:    st_d = S_WLDB;
      S_WLDB:   if (!p1_busy_q && !p0_busy_q) st_d = S_MM;
      S_MM:     st_d = S_WMM;
      S_WMM: begin
        if (mm_done) begin
          if (last_k) begin
            st_d = S_ST;
          end else begin
            st_d = S_LDB;
            step = 1'b1;
          end
        end
      end
      S_ST:     st_d = S_WST;
      S_WST: begin
        if (!p1_busy_q) begin
          if (has_next) begin
            st_d = S_LDC;
            step = 1'b1;
          end else begin
            st_d = S_FIN;
          end
        end
      end
      S_FIN:    st_d = S_IDLE;
      default:  st_d = S_IDLE;
    endcase
  end

  // Request strobes and partition 1 descriptor mux
  always_comb begin
    p0_req = ((st_q == S_LDC) && first_q) || (in_mm && pf_need);
    p1_req = (st_q == S_LDC) || (st_q == S_LDB) || (st_q == S_ST);
    if (st_q == S_LDB) begin
      p1_kind     = KIND_B_LOAD;
      p1_addr     = b_addr;
      p1_row_tile = cur_k;
      p1_rows     = b_rows;
      p1_cols     = b_cols;
    end else begin
      p1_kind     = (st_q == S_ST) ? KIND_C_STORE : KIND_C_LOAD;
      p1_addr     = c_addr;
      p1_row_tile = cur_i;
      p1_rows     = c_rows;
      p1_cols     = c_cols;
    end
    p1_col_tile = cur_j;
    p0_busy_d   = p0_req ? 1'b1 : (p0_ack ? 1'b0 : p0_busy_q);
    p1_busy_d   = p1_req ? 1'b1 : (p1_ack ? 1'b0 : p1_busy_q);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      m_q       <= '0;
      n_q       <= '0;
      k_q       <= '0;
      ba_q      <= '0;
      bb_q      <= '0;
      bc_q      <= '0;
      first_q   <= 1'b0;
      a_slot_q  <= 1'b0;
      swap_q    <= 1'b0;
      p0_busy_q <= 1'b0;
      p1_busy_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      p0_busy_q <= p0_busy_d;
      p1_busy_q <= p1_busy_d;
      if (accept) begin
        m_q      <= dim_m;
        n_q      <= dim_n;
        k_q      <= dim_k;
        ba_q     <= base_a;
        bb_q     <= base_b;
        bc_q     <= base_c;
        first_q  <= 1'b1;
        a_slot_q <= 1'b0;
      end else begin
        if (st_q == S_LDC) first_q <= 1'b0;
        if (step)          a_slot_q <= a_slot_q ^ swap_q;
      end
      if (in_mm) swap_q <= pf_need;
    end
  end

  assign mm_start  = in_mm;
  assign mm_a_slot = a_slot_q;
  assign busy      = (st_q != S_IDLE);
  assign done      = (st_q == S_FIN);

  // Partition 1 carries one transfer at a time (R4)
  assert_p1_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    p1_busy_q |-> !p1_req);

  // Compute starts only with every load acknowledged (R4)
  assert_operands_landed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mm_start |-> (!p0_busy_q && !p1_busy_q));

  // Store follows the final multiply completion by one cycle (R8)
  assert_store_after_mm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_req && p1_kind == KIND_C_STORE) |-> $past(mm_done));

  // done is a single-cycle pulse (R9)
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // done never precedes the final acknowledge (R9)
  assert_done_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !p1_busy_q);

  // No traffic while idle (R10)
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(p0_req || p1_req || mm_start));

endmodule

// File: tb/tb_gemm_tile_seq.sv
module tb_gemm_tile_seq;

  localparam int DW = 16;
  localparam int TL = 5;
  localparam int AW = 32;
  localparam int TW = DW - TL + 1;
  localparam int WD_LIMIT = 20000;

  logic          clk, rst_n, start;
  logic [DW-1:0] dim_m, dim_n, dim_k;
  logic [AW-1:0] base_a, base_b, base_c;
  logic          p0_req, p0_slot, p0_ack;
  logic [AW-1:0] p0_addr;
  logic [TW-1:0] p0_row_tile, p0_col_tile;
  logic [TL:0]   p0_rows, p0_cols;
  logic          p1_req, p1_ack;
  logic [1:0]    p1_kind;
  logic [AW-1:0] p1_addr;
  logic [TW-1:0] p1_row_tile, p1_col_tile;
  logic [TL:0]   p1_rows, p1_cols;
  logic          mm_start, mm_a_slot, mm_done, busy, done;

  gemm_tile_seq #(.DIM_W(DW), .TLOG(TL), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .dim_m(dim_m), .dim_n(dim_n), .dim_k(dim_k),
    .base_a(base_a), .base_b(base_b), .base_c(base_c),
    .p0_req(p0_req), .p0_addr(p0_addr), .p0_row_tile(p0_row_tile),
    .p0_col_tile(p0_col_tile), .p0_rows(p0_rows), .p0_cols(p0_cols),
    .p0_slot(p0_slot), .p0_ack(p0_ack),
    .p1_req(p1_req), .p1_kind(p1_kind), .p1_addr(p1_addr),
    .p1_row_tile(p1_row_tile), .p1_col_tile(p1_col_tile),
    .p1_rows(p1_rows), .p1_cols(p1_cols), .p1_ack(p1_ack),
    .mm_start(mm_start), .mm_a_slot(mm_a_slot), .mm_done(mm_done),
    .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Job description (bench-side)
  int jm, jn, jk, jmt, jnt, jkt;
  longint ja, jb, jc;
  bit job_on = 0;

  function automatic int ceil32(input int d);
    return (d + 31) / 32;
  endfunction
  function automatic int ext(input int tot, input int t);
    int r;
    r = tot - 32 * t;
    return (r > 32) ? 32 : r;
  endfunction
  function automatic longint eaddr(input longint base, input int rt, input int ct, input int stride);
    return (base + (longint'(rt) * 32 * stride + longint'(ct) * 32) * 2) & 64'hFFFF_FFFF;
  endfunction

  // Expected-sequence iterators
  int e1_i, e1_j, e1_k, e1_ph;
  int s_i, s_j, s_k; bit s_end;
  int em_i, em_j, em_k;
  int n_p0, n_p1, n_mm, n_mm_done, done_cnt, cyc, last_st_ack;
  // Responder state
  int p0_cd, p1_cd, mm_cd;
  int pend0_slot, pend0_i, pend0_k, pend1_kind, pend1_r, pend1_c;
  bit mm_active;
  int mm_slot_used;
  bit slot_v[2]; int slot_i[2]; int slot_k[2];
  bit c_v; int c_i, c_j; bit b_v; int b_k, b_j;

  task automatic step_adv(inout int i, inout int j, inout int k, output bit fin);
    fin = 0;
    if (k < jkt - 1) k++;
    else begin
      k = 0;
      if (j < jnt - 1) j++;
      else begin
        j = 0;
        if (i < jmt - 1) i++;
        else fin = 1;
      end
    end
  endtask

  task automatic adv1();
    if (e1_ph == 0) e1_ph = 1;
    else if (e1_ph == 1) begin
      if (e1_k == jkt - 1) e1_ph = 2; else e1_k++;
    end else if (e1_ph == 2) begin
      e1_k = 0;
      if (e1_j < jnt - 1) begin e1_j++; e1_ph = 0; end
      else begin
        e1_j = 0;
        if (e1_i < jmt - 1) begin e1_i++; e1_ph = 0; end
        else e1_ph = 3;
      end
    end
  endtask

  // Monitor and responders, all at the falling edge
  initial begin
    p0_ack = 0; p1_ack = 0; mm_done = 0;
    p0_cd = 0; p1_cd = 0; mm_cd = 0; cyc = 0; mm_active = 0;
    forever begin
      @(negedge clk);
      cyc++;
      p0_ack = 0; p1_ack = 0; mm_done = 0;
      if (p0_cd > 0) begin
        p0_cd--;
        if (p0_cd == 0) begin
          p0_ack = 1;
          slot_v[pend0_slot] = 1; slot_i[pend0_slot] = pend0_i; slot_k[pend0_slot] = pend0_k;
        end
      end
      if (p1_cd > 0) begin
        p1_cd--;
        if (p1_cd == 0) begin
          p1_ack = 1;
          if (pend1_kind == 0) begin c_v = 1; c_i = pend1_r; c_j = pend1_c; end
          else if (pend1_kind == 1) begin b_v = 1; b_k = pend1_r; b_j = pend1_c; end
          else last_st_ack = cyc;
        end
      end
      if (mm_cd > 0) begin
        mm_cd--;
        if (mm_cd == 0) begin mm_done = 1; mm_active = 0; n_mm_done++; end
      end

      if (done) begin
        done_cnt++;
        if (job_on && jmt * jnt * jkt > 0)
          chk(cyc - last_st_ack == 2, "R9", "done delay after store ack", cyc - last_st_ack, 2);
        chk(busy == 1'b1, "R9", "busy during done", busy, 1);
      end

      if (mm_start) begin
        chk(p0_cd == 0 && p1_cd == 0, "R4", "transfer outstanding at mm_start", p0_cd + p1_cd, 0);
        chk(slot_v[mm_a_slot] && slot_i[mm_a_slot] == em_i && slot_k[mm_a_slot] == em_k,
            "R6", "A tile in mm_a_slot (i*1000+k)",
            slot_i[mm_a_slot] * 1000 + slot_k[mm_a_slot], em_i * 1000 + em_k);
        chk(c_v && c_i == em_i && c_j == em_j, "R4", "resident C tile (i*1000+j)",
            c_i * 1000 + c_j, em_i * 1000 + em_j);
        chk(b_v && b_k == em_k && b_j == em_j, "R4", "resident B tile (k*1000+j)",
            b_k * 1000 + b_j, em_k * 1000 + em_j);
        begin bit f; step_adv(em_i, em_j, em_k, f); end
        n_mm++;
        mm_active = 1; mm_slot_used = mm_a_slot;
        mm_cd = $urandom_range(8, 1);
      end

      if (p1_req) begin
        int rt, ct, rw, cl; longint ad;
        chk(p1_cd == 0, "R4", "second p1 transfer outstanding", p1_cd, 0);
        chk(e1_ph != 3, "R2", "p1 request beyond expected sequence", n_p1, 0);
        chk(int'(p1_kind) == e1_ph, "R2", "p1 kind", p1_kind, e1_ph);
        if (e1_ph == 1) begin
          rt = e1_k; ct = e1_j; rw = ext(jk, e1_k); cl = ext(jn, e1_j); ad = eaddr(jb, e1_k, e1_j, jn);
        end else begin
          rt = e1_i; ct = e1_j; rw = ext(jm, e1_i); cl = ext(jn, e1_j); ad = eaddr(jc, e1_i, e1_j, jn);
        end
        chk(int'(p1_row_tile) == rt && int'(p1_col_tile) == ct, "R2", "p1 tile coords (r*1000+c)",
            int'(p1_row_tile) * 1000 + int'(p1_col_tile), rt * 1000 + ct);
        chk(int'(p1_rows) == rw && int'(p1_cols) == cl, "R1", "p1 extents (r*100+c)",
            int'(p1_rows) * 100 + int'(p1_cols), rw * 100 + cl);
        chk(longint'(p1_addr) == ad, "R3", "p1 address", p1_addr, ad);
        if (e1_ph == 0 && e1_i == 0 && e1_j == 0)
          chk(p0_req == 1'b1, "R5", "first A and C requested together", p0_req, 1);
        if (e1_ph == 2) begin
          chk(!mm_active && n_mm_done == (e1_i * jnt + e1_j + 1) * jkt, "R8",
              "multiplies completed before store", n_mm_done, (e1_i * jnt + e1_j + 1) * jkt);
        end
        pend1_kind = e1_ph; pend1_r = rt; pend1_c = ct;
        adv1();
        n_p1++;
        p1_cd = $urandom_range(6, 1);
      end

      if (p0_req) begin
        chk(!s_end, "R7", "A request beyond expected sequence", n_p0, 0);
        chk(int'(p0_row_tile) == s_i && int'(p0_col_tile) == s_k, "R2", "A tile coords (i*1000+k)",
            int'(p0_row_tile) * 1000 + int'(p0_col_tile), s_i * 1000 + s_k);
        chk(int'(p0_rows) == ext(jm, s_i) && int'(p0_cols) == ext(jk, s_k), "R1",
            "A extents (r*100+c)", int'(p0_rows) * 100 + int'(p0_cols),
            ext(jm, s_i) * 100 + ext(jk, s_k));
        chk(longint'(p0_addr) == eaddr(ja, s_i, s_k, jk), "R3", "A address", p0_addr, eaddr(ja, s_i, s_k, jk));
        if (n_p0 == 0) begin
          chk(p0_slot == 1'b0, "R5", "first A slot", p0_slot, 0);
        end else begin
          chk(mm_start == 1'b1, "R6", "prefetch coincides with mm_start", mm_start, 1);
          chk(p0_slot != mm_a_slot, "R6", "prefetch slot differs from compute slot", p0_slot, !mm_a_slot);
        end
        pend0_slot = p0_slot; pend0_i = s_i; pend0_k = s_k;
        slot_v[p0_slot] = 0;
        begin
          int pi, pk; bit f;
          pi = s_i; pk = s_k; f = 0;
          while (!f && s_i == pi && s_k == pk) step_adv(s_i, s_j, s_k, f);
          s_end = f;
        end
        n_p0++;
        p0_cd = $urandom_range(6, 1);
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic run_job(input int m, input int n, input int k, input bit poke);
    int wd, exp_p0, exp_p1, exp_mm;
    jm = m; jn = n; jk = k;
    jmt = ceil32(m); jnt = ceil32(n); jkt = ceil32(k);
    ja = longint'($urandom) & 64'hFFFF_FFFE; jb = longint'($urandom) & 64'hFFFF_FFFE;
    jc = longint'($urandom) & 64'hFFFF_FFFE;
    e1_i = 0; e1_j = 0; e1_k = 0; e1_ph = (jmt * jnt * jkt == 0) ? 3 : 0;
    s_i = 0; s_j = 0; s_k = 0; s_end = (jmt * jnt * jkt == 0);
    em_i = 0; em_j = 0; em_k = 0;
    n_p0 = 0; n_p1 = 0; n_mm = 0; n_mm_done = 0; done_cnt = 0; last_st_ack = 0;
    slot_v[0] = 0; slot_v[1] = 0; c_v = 0; b_v = 0;
    @(negedge clk);
    dim_m = DW'(m); dim_n = DW'(n); dim_k = DW'(k);
    base_a = AW'(ja); base_b = AW'(jb); base_c = AW'(jc);
    start = 1; job_on = 1;
    @(negedge clk);
    start = 0;
    wd = 0;
    while (done_cnt == 0 && wd < WD_LIMIT) begin
      @(negedge clk);
      wd++;
      if (poke && wd == 15) begin
        // R10: start with different operands while busy must be ignored
        dim_m = DW'(m + 40); dim_n = DW'(n + 7); dim_k = DW'(k + 33);
        base_a = ~base_a; base_b = ~base_b; base_c = ~base_c;
        start = 1;
      end else start = 0;
    end
    if (done_cnt == 0) begin
      chk(0, "R9", "watchdog expired waiting for done", wd, WD_LIMIT);
      finish_run();
    end
    repeat (12) @(negedge clk);
    exp_mm = jmt * jnt * jkt;
    exp_p1 = (exp_mm == 0) ? 0 : jmt * jnt * (jkt + 2);
    exp_p0 = (exp_mm == 0) ? 0 : ((jkt == 1) ? jmt : exp_mm);
    chk(n_p0 == exp_p0, "R7", "A request count", n_p0, exp_p0);
    chk(n_p1 == exp_p1, "R2", "partition 1 request count", n_p1, exp_p1);
    chk(n_mm == exp_mm, "R4", "multiply count", n_mm, exp_mm);
    chk(done_cnt == 1, poke ? "R10" : "R9", "done pulses per job", done_cnt, 1);
    chk(busy == 1'b0, "R9", "busy low after done", busy, 0);
    if (exp_mm == 0)
      chk(n_p0 + n_p1 + n_mm == 0, "R11", "no traffic for zero dimension", n_p0 + n_p1 + n_mm, 0);
    job_on = 0;
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_1234);
    rst_n = 0; start = 0;
    dim_m = '0; dim_n = '0; dim_k = '0; base_a = '0; base_b = '0; base_c = '0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R9", "reset busy/done", {busy, done}, 0);
    chk(p0_req == 0 && p1_req == 0 && mm_start == 0, "R10", "reset strobes",
        {p0_req, p1_req, mm_start}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // Directed corners
    run_job(32, 32, 32, 0);     // single full tile
    run_job(1, 1, 1, 0);        // smallest
    run_job(70, 100, 20, 0);    // K in one slice: A reuse across j (R7)
    run_job(64, 64, 96, 0);     // exact multiples
    run_job(45, 33, 130, 1);    // edges plus ignored start (R10)
    run_job(0, 40, 40, 0);      // zero dimension (R11)
    run_job(50, 0, 10, 0);      // zero dimension (R11)
    // Random jobs
    for (int t = 0; t < 10; t++)
      run_job($urandom_range(140, 1), $urandom_range(140, 1), $urandom_range(140, 1), t[0]);
    finish_run();
  end

endmodule